// File: doc/BRIEF.md
# Trigger DMA Request Generator

This block turns per-group conversion-chain completions into DMA request lines. It serves eight external trigger groups. Each group has an enable bit and a status flag. When a completion event arrives on an enabled group, the block sets that group's status flag and raises its DMA request line. Software clears a status flag by writing 1 to its bit in the control word.

A global mode bit selects how a raised request is withdrawn.
- **Pulsed mode:** the DMA acknowledge alone drops the request.
- **Latched mode:** the request holds until an acknowledge has been seen and the status flag has also been cleared. The two may happen in either order.

A synchronous soft-reset bit empties every flag. While that bit stays set, completion events are ignored.

Software sees the block as one 32-bit control word, written through `wr_en`/`wr_data` and always visible on `rd_data`.

Top module: `trig_dma_req_gen`

## Requirements
- R1: After `rst_n` is asserted low, `rd_data` reads 0 and every `dma_req` line is 0.
- R2: A `done_evt[g]` pulse on a group whose enable bit (control bit g, bits 7:0) is 1 sets status bit 16+g and raises `dma_req[g]` after the next clock edge.
- R3: A `done_evt[g]` pulse on a group whose enable bit is 0 sets neither the status bit nor the request.
- R4: Writing 1 to status bit 16+g clears that flag. A write with 0 in a status bit leaves that flag unchanged, including a write that changes enable bits.
- R5: In pulsed mode (control bit 30 = 1), `dma_ack[g]` while `dma_req[g]` is high drops the request at the next edge. The status bit is left as it was.
- R6: In latched mode (control bit 30 = 0), `dma_req[g]` stays high while status bit 16+g is 1, even after an acknowledge. Once an acknowledge has been seen and the status bit reads 0, the request drops at the next edge.
- R7: An enabled completion event wins over a same-cycle acknowledge or status clear. The request and the status flag both end up set.
- R8: Writing 1 to control bit 31 (soft reset) clears every status flag and request at that edge. Completion events are ignored while the bit stays 1. The enable and mode bits keep the values written.
- R9: `rd_data` shows the enables at bits 7:0, the status flags at bits 23:16, the mode at bit 30 and the soft reset at bit 31. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_evt | input | 8 | Per-group chain completion pulse |
| dma_ack | input | 8 | Per-group DMA acknowledge |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| dma_req | output | 8 | Per-group DMA request |

## Verification
The assertions assume `wr_en` carries full control words. Enables, mode and soft reset are rewritten on every write, so a stray write would legitimately alter state.

The assertions also assume that an acknowledge can arrive at any time, including when no request is pending. Such an acknowledge must be harmless. The bench stays inside these assumptions by always writing the intended enable and mode bits with each status clear. It also sends stray acknowledges in pulsed mode to show they are ignored.

// File: rtl/trig_dma_req_gen.sv
module trig_dma_req_gen #(
  parameter int NGRP     = 8,
  parameter int DW       = 32,
  parameter int STAT_LSB = 16,
  parameter int MODE_BIT = 30,
  parameter int SRST_BIT = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] done_evt,
  input  logic [NGRP-1:0] dma_ack,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic [NGRP-1:0] dma_req
);

  logic [NGRP-1:0] en_q, stat_q, req_q, ackd_q;
  logic            mode_q, srst_q;

  wire             srst_now = wr_en ? wr_data[SRST_BIT] : srst_q;
  wire [NGRP-1:0]  set_v    = done_evt & en_q & {NGRP{~srst_now}};
  wire [NGRP-1:0]  w1c_v    = wr_en ? wr_data[STAT_LSB +: NGRP] : '0;
  wire [NGRP-1:0]  ackd_v   = ackd_q | (dma_ack & req_q);
  wire [NGRP-1:0]  drop_v   = mode_q ? (dma_ack & req_q) : (ackd_v & ~stat_q);
  wire             unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= 1'b0;
      srst_q <= 1'b0;
    end else if (wr_en) begin
      en_q   <= wr_data[NGRP-1:0];
      mode_q <= wr_data[MODE_BIT];
      srst_q <= wr_data[SRST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      req_q  <= '0;
      ackd_q <= '0;
    end else if (srst_now) begin
      stat_q <= '0;
      req_q  <= '0;
      ackd_q <= '0;
    end else begin
      stat_q <= set_v | (stat_q & ~w1c_v);
      req_q  <= set_v | (req_q & ~drop_v);
      ackd_q <= ackd_v & ~set_v & ~drop_v;
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[NGRP-1:0]           = en_q;
    rd_data[STAT_LSB +: NGRP]   = stat_q;
    rd_data[MODE_BIT]           = mode_q;
    rd_data[SRST_BIT]           = srst_q;
  end

  assign dma_req = req_q;

  // R8
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> (stat_q == '0 && dma_req == '0));

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R3
    disabled_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_evt[g] && !en_q[g] && !stat_q[g] && !dma_req[g]) |=> (!stat_q[g] && !dma_req[g]));
    // R5
    pulsed_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && dma_req[g] && dma_ack[g] && !(done_evt[g] && en_q[g])) |=> !dma_req[g]);
    // R6
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && dma_req[g] && stat_q[g] && !wr_en && !srst_q) |=> dma_req[g]);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_evt[g] && en_q[g] && !srst_q && !wr_en) |=> (stat_q[g] && dma_req[g]));
    // R4
    w1c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[g] && !srst_q && !(wr_en && (wr_data[STAT_LSB+g] || wr_data[SRST_BIT]))) |=> stat_q[g]);
  end

endmodule

// File: tb/trig_dma_req_gen_tb.sv
`timescale 1ns/1ps
module trig_dma_req_gen_tb;
  localparam logic [31:0] MODE = 32'h4000_0000;
  localparam logic [31:0] SRST = 32'h8000_0000;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  done_evt = 0, dma_ack = 0, dma_req;
  logic [31:0] wr_data = 0, rd_data;
  int checks = 0, fails = 0;

  trig_dma_req_gen u_dut (.clk(clk), .rst_n(rst_n), .done_evt(done_evt), .dma_ack(dma_ack),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .dma_req(dma_req));

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = 0;
  endtask

  task automatic ev(logic [7:0] m);
    done_evt = m; step(); done_evt = 0;
  endtask

  task automatic ack(logic [7:0] m);
    dma_ack = m; step(); dma_ack = 0;
  endtask

  task automatic stat(string tag, logic [7:0] e);
    check(tag, {24'h0, rd_data[23:16]}, {24'h0, e});
  endtask

  task automatic t_reset;
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 dma_req", {24'h0, dma_req}, 32'h0);
  endtask

  task automatic t_set_disabled;
    wr(32'h0000_000F);
    ev(8'hF1);
    check("R3/R2 dma_req", {24'h0, dma_req}, 32'h01);
    stat("R3/R2 status", 8'h01);
    check("R9 rd_data", rd_data, 32'h0001_000F);
    wr(SRST); wr(32'h0);
  endtask

  task automatic t_w1c_latched;
    wr(32'h0000_00FF);
    ev(8'h05);
    check("R2 dma_req", {24'h0, dma_req}, 32'h05);
    stat("R2 status", 8'h05);
    wr(32'h0000_003F);
    stat("R4 zero write keeps", 8'h05);
    check("R4 req kept", {24'h0, dma_req}, 32'h05);
    check("R9 enables", {24'h0, rd_data[7:0]}, 32'h3F);
    wr(32'h0001_003F);
    stat("R4 w1c", 8'h04);
    step(2);
    check("R6 held no ack", {24'h0, dma_req}, 32'h05);
    ack(8'h01);
    check("R6 clear after ack", {24'h0, dma_req}, 32'h04);
    wr(SRST); wr(32'h0);
  endtask

  task automatic t_latched_ack_first;
    wr(32'h0000_00FF);
    ev(8'h02);
    ack(8'h02);
    check("R6 ack with status set", {24'h0, dma_req}, 32'h02);
    step(3);
    check("R6 still held", {24'h0, dma_req}, 32'h02);
    wr(32'h0002_00FF);
    stat("R4 cleared", 8'h00);
    step();
    check("R6 dropped", {24'h0, dma_req}, 32'h00);
    wr(SRST); wr(32'h0);
  endtask

  task automatic t_pulsed;
    wr(MODE | 32'h0000_00FF);
    ev(8'h04);
    check("R5 raised", {24'h0, dma_req}, 32'h04);
    ack(8'h04);
    check("R5 ack drops", {24'h0, dma_req}, 32'h00);
    stat("R5 status kept", 8'h04);
    ack(8'h10);
    check("R5 stray ack", {24'h0, dma_req}, 32'h00);
    wr(SRST); wr(32'h0);
  endtask

  task automatic t_set_wins;
    wr(MODE | 32'h0000_00FF);
    ev(8'h08);
    done_evt = 8'h08; dma_ack = 8'h08; step(); done_evt = 0; dma_ack = 0;
    check("R7 set beats ack", {24'h0, dma_req}, 32'h08);
    done_evt = 8'h08; wr_en = 1; wr_data = MODE | 32'h0008_00FF;
    step(); done_evt = 0; wr_en = 0; wr_data = 0;
    stat("R7 set beats w1c", 8'h08);
    wr(SRST); wr(32'h0);
  endtask

  task automatic t_softreset;
    wr(32'h0000_00FF);
    ev(8'h81);
    check("R8 pending", {24'h0, dma_req}, 32'h81);
    wr(SRST | 32'h0000_00FF);
    check("R8 req cleared", {24'h0, dma_req}, 32'h00);
    check("R8 rd_data", rd_data, 32'h8000_00FF);
    ev(8'h01);
    check("R8 event ignored", {24'h0, dma_req}, 32'h00);
    wr(32'h0000_00FF);
    ev(8'h01);
    check("R8 resumes", {24'h0, dma_req}, 32'h01);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1;
    step(2);
    t_reset();
    t_set_disabled();
    t_w1c_latched();
    t_latched_ack_first();
    t_pulsed();
    t_set_wins();
    t_softreset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule